// File: doc/BRIEF.md
# Two-Digit Time-Shared Hex Display Driver

The block shows two 4-bit values as hexadecimal characters on a pair of common-anode seven-segment digits. Both digits share one set of seven segment lines and a single hex-to-segment decoder. A refresh divider counts system clock cycles and swaps the powered digit at a fixed rate. A multiplexer steers the nibble of the powered digit into the decoder. Each digit's anode is switched by a high-side PNP transistor, so its enable is active-low.

The block also adds the two nibbles as unsigned values and drives the 5-bit result onto five LEDs, one bit per LED. The refresh rate comes from two parameters, the input clock frequency and the wanted select toggle rate. The defaults give roughly 80 swaps per second from a 12 MHz clock. The asynchronous reset input passes through a two-stage synchronizer before it is released.

Top module: `dual_digit_display`

## Requirements
- R1: While reset is active, both anode enables are high (both digits dark), all seven segment lines are high and the LED outputs are zero. Asserting rst_ni takes effect without waiting for a clock edge.
- R2: The anode enables are active-low. an_n_o[0] powers the digit that shows sw_a_i, and an_n_o[1] powers the digit that shows sw_b_i.
- R3: Segment lines are active-low, with bits 6 down to 0 driving segments g, f, e, d, c, b, a. As active-high gfedcba hex patterns, values 0 to F map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71, and the output is the bitwise inverse of the pattern.
- R4: The select alternates after every DIV = CLK_HZ / TOGGLE_HZ clock cycles. The first digit lit after reset is the sw_a_i digit, and it stays lit for DIV cycles.
- R5: led_o carries the unsigned sum sw_a_i + sw_b_i, from 0 to 30, registered one clock after the inputs are sampled.
- R6: Once the outputs are running, exactly one anode enable is low in every cycle.
- R7: The segment lines and the anode enables are loaded on the same clock edge. In every cycle the pattern shown is the one for the powered digit's nibble, as sampled on that edge.
- R8: After rst_ni rises, the outputs stay in their reset state through two rising edges and first show data on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_a_i | input | 4 | Value shown on the first digit |
| sw_b_i | input | 4 | Value shown on the second digit |
| an_n_o | output | 2 | Active-low anode enables, bit 0 for the first digit and bit 1 for the second |
| seg_n_o | output | 7 | Active-low segment lines, bit 6 is g and bit 0 is a |
| led_o | output | 5 | Sum of the two values |

## Verification
The sum assertion compares led_o with the inputs one cycle earlier, so it assumes the switch inputs are synchronous to clk_i and stable around each rising edge. The bench changes the switches only on falling edges. The anode and segment assertions assume the block is past its reset release pipeline, which a valid flag in the output stage tracks. The divider assertions assume DIV is at least 2, so the bench sets the frequency parameters to give a short period of 8 cycles. With that period, held values cross several digit swaps.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef logic [3:0] nibble_t;
  typedef logic [6:0] seg_t;
  typedef logic [1:0] anode_t;
  typedef logic [4:0] sum_t;

  localparam seg_t   SEG_DARK = 7'h7F;
  localparam anode_t AN_OFF   = 2'b11;
  localparam anode_t AN_DIG_A = 2'b10;
  localparam anode_t AN_DIG_B = 2'b01;
endpackage

// File: rtl/disp_rst_sync.sv
module disp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_no = stage2_q;
endmodule

// File: rtl/refresh_divider.sv
module refresh_divider #(
  parameter int unsigned DIV = 150000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sel_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TERM = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sel_q, sel_d;
  logic          tick;

  always_comb begin
    tick  = (cnt_q == TERM);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    sel_d = tick ? ~sel_q : sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TERM); // R4
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != TERM) |=> $stable(sel_q)); // R4
  AST_SEL_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == TERM) |=> (sel_q != $past(sel_q))); // R4
endmodule

// File: rtl/hex_seg_decoder.sv
module hex_seg_decoder
  import disp_pkg::*;
(
  input  nibble_t nib_i,
  output seg_t    seg_n_o
);
  seg_t lit;

  always_comb begin
    unique case (nib_i)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
    seg_n_o = ~lit;
  end
endmodule

// File: rtl/digit_drive.sv
module digit_drive
  import disp_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sel_i,
  input  nibble_t sw_a_i,
  input  nibble_t sw_b_i,
  input  seg_t    seg_n_i,
  output nibble_t nib_o,
  output anode_t  an_n_o,
  output seg_t    seg_n_o,
  output sum_t    led_o
);
  anode_t an_q, an_d;
  seg_t   seg_q, seg_d;
  sum_t   led_q, led_d;
  logic   valid_q;

  assign nib_o = sel_i ? sw_b_i : sw_a_i;

  always_comb begin
    an_d  = sel_i ? AN_DIG_B : AN_DIG_A;
    seg_d = seg_n_i;
    led_d = {1'b0, sw_a_i} + {1'b0, sw_b_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      an_q    <= AN_OFF;
      seg_q   <= SEG_DARK;
      led_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      an_q    <= an_d;
      seg_q   <= seg_d;
      led_q   <= led_d;
      valid_q <= 1'b1;
    end
  end

  assign an_n_o  = an_q;
  assign seg_n_o = seg_q;
  assign led_o   = led_q;

  AST_ONE_ANODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> ($countones(~an_n_o) == 1)); // R6
  AST_LED_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (led_o == 5'($past(sw_a_i)) + 5'($past(sw_b_i)))); // R5
  AST_ANODE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (an_n_o[0] == $past(sel_i))); // R2
endmodule

// File: rtl/dual_digit_display.sv
module dual_digit_display
  import disp_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 12000000,
  parameter int unsigned TOGGLE_HZ = 80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] sw_a_i,
  input  logic [3:0] sw_b_i,
  output logic [1:0] an_n_o,
  output logic [6:0] seg_n_o,
  output logic [4:0] led_o
);
  localparam int unsigned DIV = CLK_HZ / TOGGLE_HZ;

  logic    rst_sync_n;
  logic    sel;
  nibble_t nib;
  seg_t    seg_dec;

  disp_rst_sync u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  refresh_divider #(.DIV(DIV)) u_divider (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .sel_o (sel)
  );

  hex_seg_decoder u_decoder (
    .nib_i  (nib),
    .seg_n_o(seg_dec)
  );

  digit_drive u_drive (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .sel_i  (sel),
    .sw_a_i (sw_a_i),
    .sw_b_i (sw_b_i),
    .seg_n_i(seg_dec),
    .nib_o  (nib),
    .an_n_o (an_n_o),
    .seg_n_o(seg_n_o),
    .led_o  (led_o)
  );
endmodule

// File: tb/dual_digit_display_tb.sv
module dual_digit_display_tb;
  localparam int DIV = 8;

  typedef struct {
    int       due;
    bit [3:0] a;
    bit [3:0] b;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] sw_a = 4'h0;
  logic [3:0] sw_b = 4'h0;
  logic [1:0] an_n;
  logic [6:0] seg_n;
  logic [4:0] led;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    edges = 0;
  item_t sb_q[$];

  always #2 clk = ~clk;

  dual_digit_display #(.CLK_HZ(1000), .TOGGLE_HZ(125)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .sw_a_i (sw_a),
    .sw_b_i (sw_b),
    .an_n_o (an_n),
    .seg_n_o(seg_n),
    .led_o  (led)
  );

  always @(posedge clk) edges <= edges + 1;

  function automatic logic [6:0] enc(input logic [3:0] v);
    logic [6:0] p;
    case (v)
      4'h0: p = 7'h3F; 4'h1: p = 7'h06; 4'h2: p = 7'h5B; 4'h3: p = 7'h4F;
      4'h4: p = 7'h66; 4'h5: p = 7'h6D; 4'h6: p = 7'h7D; 4'h7: p = 7'h07;
      4'h8: p = 7'h7F; 4'h9: p = 7'h6F; 4'hA: p = 7'h77; 4'hB: p = 7'h7C;
      4'hC: p = 7'h39; 4'hD: p = 7'h5E; 4'hE: p = 7'h79; default: p = 7'h71;
    endcase
    return ~p;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, edges);
    end
  endtask

  task automatic check_dark(input string tag);
    check({tag, " anodes"}, an_n, 2'b11);
    check({tag, " segments"}, seg_n, 7'h7F);
    check({tag, " leds"}, led, 0);
  endtask

  // driver: sets inputs on a falling edge, expects them on the next rise
  task automatic drive(input logic [3:0] a, input logic [3:0] b, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sw_a = a;
      sw_b = b;
      sb_q.push_back('{edges + 1, a, b});
    end
  endtask

  // monitor: compares each expected item once its edge has passed
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= edges) begin
      item_t it;
      int dig;
      it  = sb_q.pop_front();
      dig = ((it.due - 3) / DIV) % 2;
      check(dig ? "R4/R2 anode (digit B)" : "R4/R2 anode (digit A)",
            an_n, dig ? 2'b01 : 2'b10);
      check("R3/R7 segments", seg_n, enc(dig ? it.b : it.a));
      check("R5 led sum", led, int'(it.a) + int'(it.b));
      check("R6 one anode", $countones(~an_n), 1);
    end
  end

  task automatic release_reset;
    @(negedge clk);
    rst_ni = 1'b1;
    edges  = 0;
    @(negedge clk);
    check_dark("R8 edge1");
    @(negedge clk);
    check_dark("R8 edge2");
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    sw_a = 4'h9;
    sw_b = 4'h6;
    repeat (3) @(negedge clk);
    check_dark("R1 reset");

    release_reset();
    drive(4'hA, 4'h5, 3 * DIV + 2);        // R4 hold across swaps
    for (int v = 0; v < 16; v++)
      drive(4'(v), 4'(15 - v), 2 * DIV);   // R3 every pattern on both digits
    drive(4'hF, 4'hF, 2);                  // R5 max sum 30
    drive(4'h0, 4'h0, 2);                  // R5 zero
    for (int i = 0; i < 40; i++)
      drive(4'(i), 4'(i * 7 + 3), 1);      // R7 values changing each cycle
    @(negedge clk);
    @(negedge clk);

    // R1 asynchronous entry into reset mid-run
    #1 rst_ni = 1'b0;
    #0.5;
    check_dark("R1 async reset");
    @(negedge clk);
    check_dark("R1 held reset");

    release_reset();
    drive(4'h3, 4'hC, 2 * DIV + 1);        // R4 digit A first again
    @(negedge clk);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule